// File: doc/BRIEF.md
# Pointer-Updating Operand Address Generator

This block produces the effective address of a memory operand for a datapath that lets an instruction reach memory through a pointer register. A request names an addressing mode, a pointer register, an external base value, a signed 16-bit displacement and an access width (byte or word). The block reads its own small pointer register file and forms the address. For the stepping modes it also computes the new pointer value and writes it back. Two modes operate on a fixed stack-pointer register, the highest-numbered one, to push and pop. A load mode seeds any pointer from the external base value.

Requests arrive on a valid/ready channel. A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both high. The pointer write-back happens on that same edge. The result of the request is presented one cycle later on a valid/ready output channel, and stays there unchanged until `res_ready` is seen high.

The input channel is ready whenever the output slot is empty, or when the output is being taken in that same cycle. This means a stalled consumer stalls the producer. A request that is not accepted leaves every pointer register untouched. All address arithmetic is modulo 2^32.

Top module: `agu_top`

## Requirements
- R1: A synchronous active-high `rst` clears all pointer registers to zero and drops `res_valid`.
- R2: Mode code 0 (register indirect) returns the selected register as the address and performs no write-back (`res_wb_en`=0). The unused code 7 behaves the same way.
- R3: Mode code 1 (indexed) returns the selected register plus `req_off` sign-extended to 32 bits, modulo 2^32, and performs no write-back.
- R4: Mode code 2 (post-increment) returns the register's value before the update as the address. The register then holds that value plus the step.
- R5: Mode code 3 (pre-decrement) first subtracts the step from the register. The reduced value is both the address and the new register contents, wrapping modulo 2^32.
- R6: The step is 4 when `req_word`=1 (word access) and 1 when `req_word`=0 (byte access).
- R7: Mode code 4 (push) acts as pre-decrement and mode code 5 (pop) acts as post-increment. Both act on register NREGS-1 whatever `req_idx` holds.
- R8: Mode code 6 (pointer load) writes `req_base` into the selected register and returns `req_base` as the address.
- R9: `res_misaligned` is 1 exactly when `req_word`=1 and the low two bits of the address are not both zero. It is never set for byte accesses.
- R10: `req_ready` equals `!res_valid || res_ready`. While `res_valid` is high and `res_ready` is low, every result output holds its value. A request that is not accepted changes no register.
- R11: For every accepted request that writes a register, `res_wb_en`=1, `res_wb_idx` names that register and `res_wb_data` holds its new value. Otherwise `res_wb_en`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_mode | input | 3 | Addressing mode code |
| req_idx | input | 3 | Pointer register index |
| req_base | input | 32 | External base value for the pointer-load mode |
| req_off | input | 16 | Signed displacement for the indexed mode |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_ea | output | 32 | Effective address |
| res_wb_en | output | 1 | A pointer register was written |
| res_wb_idx | output | 3 | Register that was written |
| res_wb_data | output | 32 | New value of that register |
| res_misaligned | output | 1 | Word access at an address not a multiple of 4 |

## Verification
The bench uses the default parameters: 32-bit addresses, 16-bit displacements and eight pointer registers. With only eight registers, random indices keep hitting the same pointers and the stack pointer. Back-to-back steps therefore read values that were written on the previous edge, and push/pop traffic mixes with ordinary pointer updates. The 32-bit width lets directed cases reach wrap-around at both ends of the address space, along with negative displacements and misaligned word pointers. A randomly toggled `res_ready` exercises the held-output and no-update-without-acceptance rules.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    AM_INDIRECT = 3'd0,
    AM_INDEXED  = 3'd1,
    AM_POSTINC  = 3'd2,
    AM_PREDEC   = 3'd3,
    AM_PUSH     = 3'd4,
    AM_POP      = 3'd5,
    AM_LOAD     = 3'd6,
    AM_RSVD     = 3'd7
  } amode_e;

  localparam int unsigned STEP_WORD = 4;
  localparam int unsigned STEP_BYTE = 1;
endpackage

// File: rtl/agu_regfile.sv
module agu_regfile #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NREGS  = 8,
  localparam int unsigned IDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_data
);
  logic [ADDR_W-1:0] regs [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        regs[g] <= wr_data;
      end
    end
  end

  assign rd_data = regs[rd_idx];

  // R11
  wb_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> regs[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/agu_calc.sv
module agu_calc
  import agu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 16
) (
  input  amode_e            mode,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  off,
  input  logic              word,
  output logic [ADDR_W-1:0] ea,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_data,
  output logic              misaligned
);
  localparam int unsigned EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] off_ext;
  logic [ADDR_W-1:0] ptr_up;
  logic [ADDR_W-1:0] ptr_dn;

  assign step    = word ? ADDR_W'(STEP_WORD) : ADDR_W'(STEP_BYTE);
  assign off_ext = {{EXT_W{off[OFF_W-1]}}, off};
  assign ptr_up  = ptr + step;
  assign ptr_dn  = ptr - step;

  always_comb begin
    ea      = ptr;
    wb_en   = 1'b0;
    wb_data = ptr;
    unique case (mode)
      AM_INDEXED: ea = ptr + off_ext;
      AM_POSTINC, AM_POP: begin
        ea      = ptr;
        wb_en   = 1'b1;
        wb_data = ptr_up;
      end
      AM_PREDEC, AM_PUSH: begin
        ea      = ptr_dn;
        wb_en   = 1'b1;
        wb_data = ptr_dn;
      end
      AM_LOAD: begin
        ea      = base;
        wb_en   = 1'b1;
        wb_data = base;
      end
      default: ea = ptr;
    endcase
  end

  assign misaligned = word && (ea[1:0] != 2'b00);
endmodule

// File: rtl/agu_outreg.sv
module agu_outreg #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] in_ea,
  input  logic              in_wb_en,
  input  logic [IDX_W-1:0]  in_wb_idx,
  input  logic [ADDR_W-1:0] in_wb_data,
  input  logic              in_mis,
  input  logic              take,
  output logic              valid,
  output logic [ADDR_W-1:0] ea,
  output logic              wb_en,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [ADDR_W-1:0] wb_data,
  output logic              mis
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid   <= 1'b0;
      ea      <= '0;
      wb_en   <= 1'b0;
      wb_idx  <= '0;
      wb_data <= '0;
      mis     <= 1'b0;
    end else if (load) begin
      valid   <= 1'b1;
      ea      <= in_ea;
      wb_en   <= in_wb_en;
      wb_idx  <= in_wb_idx;
      wb_data <= in_wb_data;
      mis     <= in_mis;
    end else if (take) begin
      valid   <= 1'b0;
    end
  end

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    valid && !take |=> valid && $stable(ea) && $stable(wb_en) && $stable(wb_idx)
                       && $stable(wb_data) && $stable(mis));
endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned NREGS  = 8,
  localparam int unsigned IDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_mode,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [OFF_W-1:0]  req_off,
  input  logic              req_word,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [ADDR_W-1:0] res_ea,
  output logic              res_wb_en,
  output logic [IDX_W-1:0]  res_wb_idx,
  output logic [ADDR_W-1:0] res_wb_data,
  output logic              res_misaligned
);
  localparam logic [IDX_W-1:0] SP_IDX = IDX_W'(NREGS - 1);

  amode_e            mode;
  logic              accept;
  logic              uses_sp;
  logic [IDX_W-1:0]  sel_idx;
  logic [ADDR_W-1:0] rd_data;
  logic [ADDR_W-1:0] c_ea;
  logic              c_wb_en;
  logic [ADDR_W-1:0] c_wb_data;
  logic              c_mis;

  assign mode      = amode_e'(req_mode);
  assign uses_sp   = (mode == AM_PUSH) || (mode == AM_POP);
  assign sel_idx   = uses_sp ? SP_IDX : req_idx;
  assign req_ready = !res_valid || res_ready;
  assign accept    = req_valid && req_ready;

  agu_regfile #(.ADDR_W(ADDR_W), .NREGS(NREGS)) i_rf (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (sel_idx),
    .rd_data (rd_data),
    .wr_en   (accept && c_wb_en),
    .wr_idx  (sel_idx),
    .wr_data (c_wb_data)
  );

  agu_calc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_calc (
    .mode       (mode),
    .ptr        (rd_data),
    .base       (req_base),
    .off        (req_off),
    .word       (req_word),
    .ea         (c_ea),
    .wb_en      (c_wb_en),
    .wb_data    (c_wb_data),
    .misaligned (c_mis)
  );

  agu_outreg #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_out (
    .clk        (clk),
    .rst        (rst),
    .load       (accept),
    .in_ea      (c_ea),
    .in_wb_en   (c_wb_en),
    .in_wb_idx  (sel_idx),
    .in_wb_data (c_wb_data),
    .in_mis     (c_mis),
    .take       (res_ready),
    .valid      (res_valid),
    .ea         (res_ea),
    .wb_en      (res_wb_en),
    .wb_idx     (res_wb_idx),
    .wb_data    (res_wb_data),
    .mis        (res_misaligned)
  );

  // R4
  postinc_old_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    accept && (mode == AM_POSTINC) |=> res_ea == $past(rd_data));

  // R3
  indexed_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    accept && (mode == AM_INDEXED) |=> res_valid && !res_wb_en);

  // R9
  byte_never_mis_chk: assert property (@(posedge clk) disable iff (rst)
    accept && !req_word |=> !res_misaligned);

  // R7
  stack_uses_sp_chk: assert property (@(posedge clk) disable iff (rst)
    accept && uses_sp |=> res_wb_en && (res_wb_idx == SP_IDX));

  // R10
  ready_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> req_ready);
endmodule

// File: tb/test_agu_top.sv
module test_agu_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_mode = '0;
  logic [2:0]  req_idx = '0;
  logic [31:0] req_base = '0;
  logic [15:0] req_off = '0;
  logic        req_word = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [31:0] res_ea;
  logic        res_wb_en;
  logic [2:0]  res_wb_idx;
  logic [31:0] res_wb_data;
  logic        res_misaligned;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;
  bit tag_reset = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  agu_top i_agu_top (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_mode(req_mode),
    .req_idx(req_idx), .req_base(req_base), .req_off(req_off), .req_word(req_word),
    .res_valid(res_valid), .res_ready(res_ready), .res_ea(res_ea),
    .res_wb_en(res_wb_en), .res_wb_idx(res_wb_idx), .res_wb_data(res_wb_data),
    .res_misaligned(res_misaligned)
  );

  // Behavioural reference model
  logic [31:0] mregs [8];
  bit          m_valid;
  logic [31:0] m_ea;
  bit          m_wb_en;
  int          m_wb_idx;
  logic [31:0] m_wb_data;
  bit          m_mis;
  string       m_tag;

  always @(posedge clk) begin
    if (rst) begin
      foreach (mregs[i]) mregs[i] = 32'd0;
      m_valid = 0;
    end else if (req_valid && (!m_valid || res_ready)) begin
      int          sel;
      logic [31:0] p;
      int          stp;
      stp = req_word ? 4 : 1;
      sel = (req_mode == 4 || req_mode == 5) ? 7 : int'(req_idx);
      p = mregs[sel];
      m_wb_en = 0;
      m_wb_idx = sel;
      m_wb_data = p;
      case (req_mode)
        1: begin m_ea = p + {{16{req_off[15]}}, req_off}; m_tag = "R3"; end
        2: begin m_ea = p; m_wb_en = 1; m_wb_data = p + stp; m_tag = "R4"; end
        3: begin m_wb_en = 1; m_wb_data = p - stp; m_ea = m_wb_data; m_tag = "R5"; end
        4: begin m_wb_en = 1; m_wb_data = p - stp; m_ea = m_wb_data; m_tag = "R7"; end
        5: begin m_ea = p; m_wb_en = 1; m_wb_data = p + stp; m_tag = "R7"; end
        6: begin m_ea = req_base; m_wb_en = 1; m_wb_data = req_base; m_tag = "R8"; end
        default: begin m_ea = p; m_tag = "R2"; end
      endcase
      if (tag_reset) m_tag = "R1";
      if (req_mode >= 2 && req_mode <= 5) m_tag = {m_tag, "/R6"};
      if (m_wb_en) mregs[sel] = m_wb_data;
      m_mis = req_word && (m_ea[1:0] != 2'b00);
      m_valid = 1;
    end else if (res_ready) begin
      m_valid = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(res_valid == m_valid, "R10 res_valid", 32'(res_valid), 32'(m_valid));
    if (m_valid && res_valid) begin
      chk(res_ea == m_ea, {m_tag, " ea"}, res_ea, m_ea);
      chk(res_wb_en == m_wb_en, {m_tag, " R11 wb_en"}, 32'(res_wb_en), 32'(m_wb_en));
      if (m_wb_en) begin
        chk(int'(res_wb_idx) == m_wb_idx, "R11 wb_idx", 32'(res_wb_idx), 32'(m_wb_idx));
        chk(res_wb_data == m_wb_data, {m_tag, " R11 wb_data"}, res_wb_data, m_wb_data);
      end
      chk(res_misaligned == m_mis, "R9 misaligned", 32'(res_misaligned), 32'(m_mis));
    end
  endtask

  // one cycle: check outputs at negedge, drive next inputs, then check ready
  task automatic step(input bit v, input int mode, input int idx, input logic [31:0] base,
                      input logic [15:0] off, input bit word, input bit rdy);
    @(negedge clk);
    compare();
    req_valid = v; req_mode = 3'(mode); req_idx = 3'(idx);
    req_base = base; req_off = off; req_word = word; res_ready = rdy;
    #1;
    chk(req_ready == (!m_valid || res_ready), "R10 req_ready", 32'(req_ready),
        32'(!m_valid || res_ready));
  endtask

  task automatic rq(input int mode, input int idx, input logic [31:0] base,
                    input logic [15:0] off, input bit word);
    step(1, mode, idx, base, off, word, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: nothing valid right after reset, all registers read zero
    chk(res_valid == 1'b0, "R1 res_valid after reset", 32'(res_valid), 32'd0);
    tag_reset = 1;
    for (int i = 0; i < 8; i++) rq(0, i, 32'hFFFF_FFFF, 16'h0, 1'b1);
    step(0, 0, 0, 0, 0, 0, 1);
    tag_reset = 0;

    // R8 loads, R2 indirect, R3 indexed with positive and negative offsets
    rq(6, 1, 32'h0000_1000, 0, 1);
    rq(0, 1, 0, 0, 1);
    rq(1, 1, 0, 16'h0010, 1);
    rq(1, 1, 0, 16'hFFF0, 1);
    rq(1, 1, 0, 16'h8000, 0);
    rq(7, 1, 0, 0, 1);
    // R4/R6 post-increment word then byte; R9 misaligned after byte step
    rq(2, 1, 0, 0, 1);
    rq(2, 1, 0, 0, 0);
    rq(0, 1, 0, 0, 1);
    // R5 pre-decrement, wrap below zero
    rq(6, 2, 32'h0, 0, 1);
    rq(3, 2, 0, 0, 1);
    rq(3, 2, 0, 0, 0);
    // post-increment wrap past the top
    rq(6, 3, 32'hFFFF_FFFF, 0, 0);
    rq(2, 3, 0, 0, 0);
    rq(0, 3, 0, 0, 0);
    // R7 push/pop on register 7 regardless of idx
    rq(6, 7, 32'h0000_2000, 0, 1);
    rq(4, 0, 0, 0, 1);
    rq(4, 5, 0, 0, 0);
    rq(5, 2, 0, 0, 0);
    rq(5, 4, 0, 0, 1);
    rq(0, 7, 0, 0, 1);
    // R10 stall: result held, request not accepted, no register change
    rq(2, 1, 0, 0, 1);
    step(1, 2, 1, 0, 0, 1, 0);
    step(1, 2, 1, 0, 0, 1, 0);
    step(1, 2, 1, 0, 0, 1, 0);
    step(1, 0, 1, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 0, 1);

    // random mix with random back-pressure
    for (int n = 0; n < 4000; n++) begin
      int m;
      logic [31:0] b;
      m = $urandom_range(0, 7);
      b = $urandom;
      if ($urandom_range(0, 3) == 0) b[1:0] = 2'b00;
      step($urandom_range(0, 3) != 0, m, $urandom_range(0, 7), b, 16'($urandom),
           $urandom_range(0, 1) == 1, $urandom_range(0, 2) != 0);
    end
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    finish_run();
  end
endmodule